// File: doc/BRIEF.md
# TDM Time-Slot Capture and Insert Pair

This block sits on a two-line serial time-division-multiplexed bus. One line carries upstream data and the other carries downstream data. It holds two byte-wide access registers. Each register takes one byte from a chosen time slot and can put a byte back into a time slot on the opposite line. This lets a host move a channel from one line to the other, or move it between slots, with no per-frame software work.

Each register has a slot index and a direction bit. Direction 0 captures from the upstream line and drives the downstream line. Direction 1 captures from the downstream line and drives the upstream line. A swap control makes each register capture through the other register's slot and direction, while each register still drives through its own settings. With swap set, a byte can therefore be moved from one slot to another. Separate enables gate the capture and the drive of each register. What a register drives in a frame is the value it held when that frame started.

The bus bit clock and frame sync are sampled by the block's system clock. They must be synchronous to it, and each bit-clock phase must last at least two system clock cycles. A frame-sync high level seen at a bit-clock rising edge marks bit 0 of slot 0.

Top module: `tdm_slot_pair`

## Requirements
- R1: After a synchronous active-low reset, both read-back bytes are 0x00, both drive enables are low and both serial outputs are 1. Nothing is captured or driven until the first frame sync.
- R2: A register with capture enabled takes the 8 bits of its capture slot, MSB first, at the falling bit-clock edges. Slots are numbered 0 to 11 from the frame sync, and each slot is 8 bits. The source line is upstream for direction 0 and downstream for direction 1. The new byte appears on its read-back port once the last bit of the slot has been sampled.
- R3: A register with drive enabled launches its byte MSB first at the rising bit-clock edges of its own slot. It drives the downstream line for direction 0 and the upstream line for direction 1. The drive enable of that line is high for exactly those 8 bits.
- R4: With swap = 1, register 0 captures using register 1's slot and direction, and register 1 captures using register 0's slot and direction.
- R5: Swap has no effect on driving. Each register always drives using its own slot and direction.
- R6: While a register's capture enable is low, its read-back byte keeps its value.
- R7: While a register's drive enable is low, it never asserts a drive enable. Whenever a line's drive enable is low, that line's serial output is 1.
- R8: The byte driven in a frame is the value the register held at that frame's sync. A register that captures and drives the same slot returns the previous frame's byte, which gives a one-frame loop latency.
- R9: A slot index of 12 or above never matches. Such a register captures nothing and drives nothing.
- R10: When both registers drive the same slot on the same line, register 0's byte is driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bclk | input | 1 | Bus bit clock, synchronous to clk |
| fsync | input | 1 | Frame sync, high across bit 0 of slot 0 |
| up_in | input | 1 | Upstream serial line as received |
| dn_in | input | 1 | Downstream serial line as received |
| cfg_slot0 | input | 4 | Register 0 slot index |
| cfg_dir0 | input | 1 | Register 0 direction (0: capture up, drive down) |
| cfg_slot1 | input | 4 | Register 1 slot index |
| cfg_dir1 | input | 1 | Register 1 direction |
| swap | input | 1 | Exchange capture selections between the registers |
| in_en | input | 2 | Capture enable, bit i for register i |
| out_en | input | 2 | Drive enable, bit i for register i |
| up_out | output | 1 | Data driven onto the upstream line |
| up_oe | output | 1 | Upstream drive enable |
| dn_out | output | 1 | Data driven onto the downstream line |
| dn_oe | output | 1 | Downstream drive enable |
| rd_data0 | output | 8 | Register 0 contents |
| rd_data1 | output | 8 | Register 1 contents |

## Verification
Two kinds of fault in the slot position counter show up within the next frame. An off-by-one fault makes the captured byte wrong by a shifted bit pattern, and a counter that does not restart moves a drive burst into a neighbouring slot. A fault in the swap path shows up as a byte read from the wrong line or slot on the read-back port as soon as the capture slot ends. A frame-start latch that fails would return the current frame's byte instead of the previous one, which a same-slot loop exposes within a single frame. Drive-enable faults show up as bursts whose length is not 0 or 8 bits, or as bursts on the wrong line.

// File: rtl/tdm_pair_pkg.sv
// Shared encodings for the TDM capture/insert pair.
// Assumes: two serial lines, one upstream and one downstream.
package tdm_pair_pkg;

    // Direction of a register: which line it captures from and which it drives.
    typedef enum logic {
        DIR_UP_TO_DN = 1'b0,   // capture upstream, drive downstream
        DIR_DN_TO_UP = 1'b1    // capture downstream, drive upstream
    } dir_e;

    localparam int unsigned LANES = 2;

endpackage

// File: rtl/tdm_frame_timer.sv
// Frame timer: detects bit-clock edges in the system clock domain and tracks
// the slot/bit position of the bus.
// Assumes bclk and fsync are synchronous to clk and each bclk phase lasts at
// least two clk cycles. fsync high at a rising edge marks slot 0, bit 0.
// The position advances at each rising edge and holds at an idle value past
// the last slot, or before the first sync.
module tdm_frame_timer #(
    parameter int unsigned NUM_SLOTS = 12,
    parameter int unsigned SLOT_BITS = 8,
    parameter int unsigned TS_W      = 4,
    parameter int unsigned BIT_W     = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bclk,
    input  logic             fsync,
    output logic             rise_stb,
    output logic             fall_stb,
    output logic             frame_start,
    output logic [TS_W-1:0]  rise_slot,
    output logic [BIT_W-1:0] rise_bit,
    output logic             rise_valid,
    output logic [TS_W-1:0]  fall_slot,
    output logic [BIT_W-1:0] fall_bit,
    output logic             fall_valid
);

    localparam logic [TS_W-1:0]  IDLE_SLOT = TS_W'(NUM_SLOTS);
    localparam logic [BIT_W-1:0] LAST_BIT  = BIT_W'(SLOT_BITS - 1);

    logic             bclk_d;
    logic [TS_W-1:0]  pos_slot_q;
    logic [BIT_W-1:0] pos_bit_q;
    logic [TS_W-1:0]  nxt_slot;
    logic [BIT_W-1:0] nxt_bit;

    // Delay the bit clock by one cycle for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) bclk_d <= 1'b0;
        else        bclk_d <= bclk;
    end

    assign rise_stb    = bclk & ~bclk_d;
    assign fall_stb    = ~bclk & bclk_d;
    assign frame_start = rise_stb & fsync;

    // Position of the bit that the current rising edge starts.
    always_comb begin
        nxt_slot = pos_slot_q;
        nxt_bit  = pos_bit_q;
        if (fsync) begin
            nxt_slot = '0;
            nxt_bit  = '0;
        end else if (pos_slot_q >= IDLE_SLOT) begin
            nxt_slot = IDLE_SLOT;
            nxt_bit  = '0;
        end else if (pos_bit_q == LAST_BIT) begin
            nxt_slot = pos_slot_q + 1'b1;
            nxt_bit  = '0;
        end else begin
            nxt_bit  = pos_bit_q + 1'b1;
        end
    end

    // Register the bus position at each rising bit-clock edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_slot_q <= IDLE_SLOT;
            pos_bit_q  <= '0;
        end else if (rise_stb) begin
            pos_slot_q <= nxt_slot;
            pos_bit_q  <= nxt_bit;
        end
    end

    assign rise_slot  = nxt_slot;
    assign rise_bit   = nxt_bit;
    assign rise_valid = (nxt_slot < IDLE_SLOT);
    assign fall_slot  = pos_slot_q;
    assign fall_bit   = pos_bit_q;
    assign fall_valid = (pos_slot_q < IDLE_SLOT);

    AST_SYNC_RESTARTS_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> (fall_slot == '0 && fall_bit == '0)); // R2

    AST_BCLK_EDGE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rise_stb |=> !rise_stb); // R2

endmodule

// File: rtl/tdm_capture_lane.sv
// Capture lane: one access register. It shifts in its selected slot at
// falling edges and commits the byte after the slot's last bit. It latches a
// transmit copy at each frame sync and presents the bit to launch at each
// rising edge.
// Assumes the selections stay stable while their slot is on the bus.
module tdm_capture_lane
    import tdm_pair_pkg::*;
#(
    parameter int unsigned SLOT_BITS = 8,
    parameter int unsigned TS_W      = 4,
    parameter int unsigned BIT_W     = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 fall_stb,
    input  logic [TS_W-1:0]      fall_slot,
    input  logic [BIT_W-1:0]     fall_bit,
    input  logic                 fall_valid,
    input  logic                 frame_start,
    input  logic [BIT_W-1:0]     rise_bit,
    input  logic                 up_in,
    input  logic                 dn_in,
    input  logic [TS_W-1:0]      cap_slot,
    input  dir_e                 cap_dir,
    input  logic                 in_en,
    output logic [SLOT_BITS-1:0] data_q,
    output logic                 drv_bit
);

    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(SLOT_BITS - 1);

    logic [SLOT_BITS-1:0] shreg_q;
    logic [SLOT_BITS-1:0] tx_q;
    logic [SLOT_BITS-1:0] tx_src;
    logic [SLOT_BITS-1:0] shifted;
    logic                 din;
    logic                 hit;

    assign din     = (cap_dir == DIR_DN_TO_UP) ? dn_in : up_in;
    assign hit     = fall_stb && fall_valid && (fall_slot == cap_slot);
    assign shifted = {shreg_q[SLOT_BITS-2:0], din};

    // Shift the selected slot in, MSB first.
    always_ff @(posedge clk) begin
        if (!rst_n)   shreg_q <= '0;
        else if (hit) shreg_q <= shifted;
    end

    // Commit the byte after its last bit when capture is enabled.
    always_ff @(posedge clk) begin
        if (!rst_n)                                    data_q <= '0;
        else if (hit && in_en && fall_bit == LAST_BIT) data_q <= shifted;
    end

    // Keep the byte that was held at frame sync for driving in this frame.
    always_ff @(posedge clk) begin
        if (!rst_n)           tx_q <= '0;
        else if (frame_start) tx_q <= data_q;
    end

    assign tx_src  = frame_start ? data_q : tx_q;
    assign drv_bit = tx_src[LAST_BIT - rise_bit];

    AST_CAPTURE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !in_en |=> $stable(data_q)); // R6

    AST_TX_FRAME_COPY: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> (tx_q == $past(data_q))); // R8

endmodule

// File: rtl/tdm_line_driver.sv
// Line driver: merges the drive requests of the lanes onto the two lines.
// Its outputs are registered at each rising bit-clock edge and hold for the
// whole bit. A lane with a lower index wins a collision. A released line
// reads as all ones.
// Assumes the lanes present their launch bit in the rising-edge cycle.
module tdm_line_driver
    import tdm_pair_pkg::*;
#(
    parameter int unsigned TS_W  = 4,
    parameter int unsigned NLANE = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       rise_stb,
    input  logic [TS_W-1:0]            rise_slot,
    input  logic                       rise_valid,
    input  logic [NLANE-1:0][TS_W-1:0] drv_slot,
    input  logic [NLANE-1:0]           drv_dir,
    input  logic [NLANE-1:0]           out_en,
    input  logic [NLANE-1:0]           drv_bit,
    output logic                       up_out,
    output logic                       up_oe,
    output logic                       dn_out,
    output logic                       dn_oe
);

    logic [NLANE-1:0] req_up;
    logic [NLANE-1:0] req_dn;
    logic             up_bit;
    logic             dn_bit;

    // Decode, per lane, which line it asks to drive in this bit.
    for (genvar i = 0; i < NLANE; i++) begin : g_req
        logic slot_hit;
        assign slot_hit  = out_en[i] && rise_valid && (drv_slot[i] == rise_slot);
        assign req_up[i] = slot_hit && (drv_dir[i] == DIR_DN_TO_UP);
        assign req_dn[i] = slot_hit && (drv_dir[i] == DIR_UP_TO_DN);
    end

    // Pick the lowest-indexed requester per line; released lines read as 1.
    always_comb begin
        up_bit = 1'b1;
        dn_bit = 1'b1;
        for (int i = NLANE - 1; i >= 0; i--) begin
            if (req_up[i]) up_bit = drv_bit[i];
            if (req_dn[i]) dn_bit = drv_bit[i];
        end
    end

    // Launch the line values at each rising bit-clock edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            up_out <= 1'b1;
            up_oe  <= 1'b0;
            dn_out <= 1'b1;
            dn_oe  <= 1'b0;
        end else if (rise_stb) begin
            up_out <= up_bit;
            up_oe  <= |req_up;
            dn_out <= dn_bit;
            dn_oe  <= |req_dn;
        end
    end

    AST_RELEASED_UP_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        !up_oe |-> up_out); // R7

    AST_RELEASED_DN_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        !dn_oe |-> dn_out); // R7

    AST_HOLD_BETWEEN_RISES: assert property (@(posedge clk) disable iff (!rst_n)
        !rise_stb |=> ($stable(up_oe) && $stable(dn_oe) && $stable(up_out) && $stable(dn_out))); // R3

endmodule

// File: rtl/tdm_slot_pair.sv
// Top: pair of TDM slot access registers. It routes each register's capture
// selection, through the swap cross-connect, and its own drive selection.
// Assumes NUM_SLOTS < 2**TS_W so that an idle slot value exists.
module tdm_slot_pair
    import tdm_pair_pkg::*;
#(
    parameter int unsigned NUM_SLOTS = 12,
    parameter int unsigned SLOT_BITS = 8,
    parameter int unsigned TS_W      = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bclk,
    input  logic                 fsync,
    input  logic                 up_in,
    input  logic                 dn_in,
    input  logic [TS_W-1:0]      cfg_slot0,
    input  logic                 cfg_dir0,
    input  logic [TS_W-1:0]      cfg_slot1,
    input  logic                 cfg_dir1,
    input  logic                 swap,
    input  logic [1:0]           in_en,
    input  logic [1:0]           out_en,
    output logic                 up_out,
    output logic                 up_oe,
    output logic                 dn_out,
    output logic                 dn_oe,
    output logic [SLOT_BITS-1:0] rd_data0,
    output logic [SLOT_BITS-1:0] rd_data1
);

    localparam int unsigned BIT_W = $clog2(SLOT_BITS);

    logic             rise_stb, fall_stb, frame_start;
    logic [TS_W-1:0]  rise_slot, fall_slot;
    logic [BIT_W-1:0] rise_bit, fall_bit;
    logic             rise_valid, fall_valid;

    logic [LANES-1:0][TS_W-1:0]      own_slot;
    logic [LANES-1:0]                own_dir;
    logic [LANES-1:0][SLOT_BITS-1:0] lane_data;
    logic [LANES-1:0]                lane_bit;

    assign own_slot = {cfg_slot1, cfg_slot0};
    assign own_dir  = {cfg_dir1, cfg_dir0};

    tdm_frame_timer #(
        .NUM_SLOTS (NUM_SLOTS),
        .SLOT_BITS (SLOT_BITS),
        .TS_W      (TS_W),
        .BIT_W     (BIT_W)
    ) u_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .bclk        (bclk),
        .fsync       (fsync),
        .rise_stb    (rise_stb),
        .fall_stb    (fall_stb),
        .frame_start (frame_start),
        .rise_slot   (rise_slot),
        .rise_bit    (rise_bit),
        .rise_valid  (rise_valid),
        .fall_slot   (fall_slot),
        .fall_bit    (fall_bit),
        .fall_valid  (fall_valid)
    );

    // One lane per register; swap crosses the capture selections only.
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic [TS_W-1:0] cap_slot;
        dir_e            cap_dir;
        assign cap_slot = swap ? own_slot[LANES-1-i] : own_slot[i];
        assign cap_dir  = dir_e'(swap ? own_dir[LANES-1-i] : own_dir[i]);

        tdm_capture_lane #(
            .SLOT_BITS (SLOT_BITS),
            .TS_W      (TS_W),
            .BIT_W     (BIT_W)
        ) u_lane (
            .clk         (clk),
            .rst_n       (rst_n),
            .fall_stb    (fall_stb),
            .fall_slot   (fall_slot),
            .fall_bit    (fall_bit),
            .fall_valid  (fall_valid),
            .frame_start (frame_start),
            .rise_bit    (rise_bit),
            .up_in       (up_in),
            .dn_in       (dn_in),
            .cap_slot    (cap_slot),
            .cap_dir     (cap_dir),
            .in_en       (in_en[i]),
            .data_q      (lane_data[i]),
            .drv_bit     (lane_bit[i])
        );
    end

    tdm_line_driver #(
        .TS_W  (TS_W),
        .NLANE (LANES)
    ) u_driver (
        .clk        (clk),
        .rst_n      (rst_n),
        .rise_stb   (rise_stb),
        .rise_slot  (rise_slot),
        .rise_valid (rise_valid),
        .drv_slot   (own_slot),
        .drv_dir    (own_dir),
        .out_en     (out_en),
        .drv_bit    (lane_bit),
        .up_out     (up_out),
        .up_oe      (up_oe),
        .dn_out     (dn_out),
        .dn_oe      (dn_oe)
    );

    assign rd_data0 = lane_data[0];
    assign rd_data1 = lane_data[1];

    AST_IDLE_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_stb && !rise_valid) |=> (!up_oe && !dn_oe)); // R9

    AST_DRIVE_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_stb && out_en == 2'b00) |=> (!up_oe && !dn_oe)); // R7

    AST_ONE_LINE_PER_LANE: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_stb && out_en == 2'b01 && cfg_dir0 == DIR_UP_TO_DN) |=> !up_oe); // R5

endmodule

// File: tb/tdm_slot_pair_tb.sv
// Bench for tdm_slot_pair: a vector table walked by one loop, then directed
// tests for reset, hold, loop latency, idle slots and collisions.
module tdm_slot_pair_tb;

    localparam int NSLOT = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bclk = 1'b0, fsync = 1'b0, up_in = 1'b1, dn_in = 1'b1;
    logic [3:0] cfg_slot0 = '0, cfg_slot1 = '0;
    logic cfg_dir0 = 1'b0, cfg_dir1 = 1'b0, swap = 1'b0;
    logic [1:0] in_en = 2'b00, out_en = 2'b00;
    logic up_out, up_oe, dn_out, dn_oe;
    logic [7:0] rd_data0, rd_data1;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    // Per-frame observation: byte seen and number of enabled bits per slot.
    logic [7:0] obs_byte [2][NSLOT];
    int         obs_cnt  [2][NSLOT];

    always #2 clk = ~clk;

    tdm_slot_pair u_dut (
        .clk(clk), .rst_n(rst_n), .bclk(bclk), .fsync(fsync),
        .up_in(up_in), .dn_in(dn_in),
        .cfg_slot0(cfg_slot0), .cfg_dir0(cfg_dir0),
        .cfg_slot1(cfg_slot1), .cfg_dir1(cfg_dir1),
        .swap(swap), .in_en(in_en), .out_en(out_en),
        .up_out(up_out), .up_oe(up_oe), .dn_out(dn_out), .dn_oe(dn_oe),
        .rd_data0(rd_data0), .rd_data1(rd_data1)
    );

    // Bus pattern: line 0 is upstream, line 1 downstream.
    function automatic logic [7:0] pat(input int f, input int line, input int s);
        logic [7:0] b;
        b = {4'(f), 4'(s)};
        return (line == 0) ? b : ~b;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // One bus frame of NSLOT*8 bits; records what the DUT drives.
    task automatic run_frame(input int f);
        for (int s = 0; s < NSLOT; s++) begin
            for (int b = 0; b < 8; b++) begin
                logic [7:0] u, d;
                u = pat(f, 0, s);
                d = pat(f, 1, s);
                bclk  = 1'b1;
                fsync = (s == 0 && b == 0);
                up_in = u[7-b];
                dn_in = d[7-b];
                @(negedge clk); @(negedge clk);
                bclk = 1'b0;
                @(negedge clk);
                if (b == 0) begin
                    obs_cnt[0][s] = 0; obs_cnt[1][s] = 0;
                end
                obs_byte[0][s][7-b] = up_out;
                obs_byte[1][s][7-b] = dn_out;
                if (up_oe) obs_cnt[0][s]++;
                if (dn_oe) obs_cnt[1][s]++;
                @(negedge clk);
            end
        end
        fsync = 1'b0;
    endtask

    typedef struct packed {
        logic [3:0] ts0;
        logic       d0;
        logic [3:0] ts1;
        logic       d1;
        logic       sw;
        logic [1:0] oen;
        logic [7:0] exp0;
        logic [7:0] exp1;
    } vec_t;

    // Captures happen in frame 0, drives are checked in frame 1.
    localparam int NVEC = 5;
    localparam vec_t VECS [NVEC] = '{
        '{4'd2,  1'b0, 4'd7,  1'b1, 1'b0, 2'b11, 8'h02, 8'hF8},  // R2 R3 plain
        '{4'd1,  1'b0, 4'd9,  1'b0, 1'b1, 2'b11, 8'h09, 8'h01},  // R4 R5 shift
        '{4'd0,  1'b1, 4'd11, 1'b0, 1'b1, 2'b11, 8'h0B, 8'hFF},  // R4 R5 edge slots
        '{4'd6,  1'b1, 4'd3,  1'b1, 1'b0, 2'b01, 8'hF9, 8'hFC},  // R7 reg1 off
        '{4'd5,  1'b0, 4'd5,  1'b1, 1'b0, 2'b10, 8'h05, 8'hFA}   // R7 reg0 off
    };

    // Check a whole frame of drive observations against the given model.
    task automatic check_lines(input string req,
                               input logic [3:0] t0, input logic dd0, input logic e0, input logic [7:0] v0,
                               input logic [3:0] t1, input logic dd1, input logic e1, input logic [7:0] v1);
        for (int line = 0; line < 2; line++) begin
            for (int s = 0; s < NSLOT; s++) begin
                logic h0, h1;
                h0 = e0 && (int'(t0) == s) && (int'(dd0) != line);
                h1 = e1 && (int'(t1) == s) && (int'(dd1) != line);
                if (h0 || h1) begin
                    check({req, " burst"}, obs_cnt[line][s], 8);
                    check({req, " byte"}, obs_byte[line][s], h0 ? v0 : v1);
                end else begin
                    check({req, " silent"}, obs_cnt[line][s], 0);
                    check({req, " ones"}, obs_byte[line][s], 8'hFF);
                end
            end
        end
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin : main
        logic [7:0] prev0, prev1;
        repeat (4) @(negedge clk);
        // R1: reset state, and nothing driven before the first sync.
        check("R1 rd0", rd_data0, 8'h00);
        check("R1 rd1", rd_data1, 8'h00);
        check("R1 oe", {up_oe, dn_oe}, 2'b00);
        check("R1 out", {up_out, dn_out}, 2'b11);
        rst_n = 1'b1;
        out_en = 2'b11;
        for (int i = 0; i < 6; i++) begin
            bclk = ~bclk; @(negedge clk); @(negedge clk);
        end
        check("R1 pre-sync oe", {up_oe, dn_oe}, 2'b00);
        check("R1 pre-sync rd", {rd_data0, rd_data1}, 16'h0000);

        // Table walk.
        for (int v = 0; v < NVEC; v++) begin
            cfg_slot0 = VECS[v].ts0; cfg_dir0 = VECS[v].d0;
            cfg_slot1 = VECS[v].ts1; cfg_dir1 = VECS[v].d1;
            swap = VECS[v].sw; out_en = VECS[v].oen; in_en = 2'b11;
            run_frame(0);
            check("R2 R4 rd0", rd_data0, VECS[v].exp0);
            check("R2 R4 rd1", rd_data1, VECS[v].exp1);
            run_frame(1);
            check_lines("R3 R5 R7", VECS[v].ts0, VECS[v].d0, VECS[v].oen[0], VECS[v].exp0,
                        VECS[v].ts1, VECS[v].d1, VECS[v].oen[1], VECS[v].exp1);
        end

        // R6: register 1 capture disabled keeps its byte.
        cfg_slot0 = 4'd3; cfg_dir0 = 1'b0; cfg_slot1 = 4'd4; cfg_dir1 = 1'b0;
        swap = 1'b0; in_en = 2'b01; out_en = 2'b00;
        prev1 = rd_data1;
        run_frame(2);
        check("R6 rd0 captured", rd_data0, 8'h23);
        check("R6 rd1 held", rd_data1, prev1);

        // R8: same-slot loop returns the previous frame's byte.
        cfg_slot0 = 4'd8; out_en = 2'b01;
        prev0 = rd_data0;
        run_frame(3);
        check("R8 loop byte", obs_byte[1][8], prev0);
        check("R8 loop burst", obs_cnt[1][8], 8);
        check("R8 new capture", rd_data0, 8'h38);

        // R9: slot indexes past the frame never match.
        cfg_slot0 = 4'd13; cfg_slot1 = 4'd12; in_en = 2'b11; out_en = 2'b11;
        prev0 = rd_data0; prev1 = rd_data1;
        run_frame(4);
        check("R9 rd0", rd_data0, prev0);
        check("R9 rd1", rd_data1, prev1);
        check_lines("R9", 4'd13, 1'b0, 1'b0, 8'h00, 4'd12, 1'b0, 1'b0, 8'h00);

        // R10: collision on the same line and slot, register 0 wins.
        cfg_slot0 = 4'd4; cfg_dir0 = 1'b0; cfg_slot1 = 4'd4; cfg_dir1 = 1'b1;
        in_en = 2'b11; out_en = 2'b00;
        run_frame(5);
        check("R10 setup rd0", rd_data0, 8'h54);
        check("R10 setup rd1", rd_data1, 8'hAB);
        cfg_dir1 = 1'b0; in_en = 2'b00; out_en = 2'b11;
        run_frame(6);
        check_lines("R10", 4'd4, 1'b0, 1'b1, 8'h54, 4'd4, 1'b0, 1'b1, 8'hAB);
        check("R6 R10 rd1 held", rd_data1, 8'hAB);

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule